// File: doc/BRIEF.md
# AXI Write-Path Packet Buffer

This block sits between an upstream AXI master and a downstream AXI slave on the write side only. It holds write addresses in a small address queue and write-data beats in a deeper data queue, 32 entries by default. Write responses pass straight through without storage. Addresses leave in the order they arrived, and so do data beats.

A build-time switch selects one of two release policies. In streaming mode the two queues act as plain independent FIFOs. An address can go downstream as soon as it is queued, and data beats drain whenever they are present. In packet mode an address is held back until its whole burst, up to and including the last beat, sits in the data queue. Data beats go downstream only for bursts whose address has already been released. As a result, once a burst starts downstream it runs to its last beat without a gap caused by the queue running empty.

Top module: `wr_pkt_fifo`

## Requirements
- R1: While reset is held, `m_aw_valid` and `m_w_valid` are low. On the first cycle after reset `s_aw_ready` and `s_w_ready` are high.
- R2: In packet mode, `m_aw_valid` is never high for a queued address until the beat flagged by `s_w_last` (bit value 1) for that burst has been accepted upstream. It rises in the cycle right after that handshake when nothing else is pending.
- R3: In packet mode, once a beat of a burst has been accepted downstream with `m_w_last` low, `m_w_valid` stays high on every following cycle until the beat with `m_w_last` high has been accepted.
- R4: Addresses (id, address, length) and data beats (data, strobe, last) leave downstream unchanged and in upstream arrival order. A presented address stays stable until it is accepted.
- R5: `s_w_ready` is low exactly when the data queue holds `W_DEPTH` beats.
- R6: `s_aw_ready` is low when the address queue holds `AW_DEPTH` entries.
- R7: In streaming mode a queued address is presented downstream in the cycle after it is accepted, even with no data stored. A queued beat is presented even when its burst is incomplete.
- R8: The response channel is combinational: `s_b_valid`, `s_b_id` and `s_b_resp` follow `m_b_valid`, `m_b_id` and `m_b_resp`, and `m_b_ready` follows `s_b_ready`, in the same cycle.
- R9: In packet mode, a burst whose beat count (`s_aw_len` + 1) exceeds `W_DEPTH` is a configuration error and is flagged by an assertion.
- R10: In packet mode, `m_w_valid` is low while every stored beat belongs to a burst whose address has not been released downstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_aw_id | input | ID_W | Upstream write address id |
| s_aw_addr | input | ADDR_W | Upstream write address |
| s_aw_len | input | LEN_W | Upstream burst length minus one |
| s_aw_valid | input | 1 | Upstream address valid |
| s_aw_ready | output | 1 | Upstream address ready |
| s_w_data | input | DATA_W | Upstream write data |
| s_w_strb | input | DATA_W/8 | Upstream byte strobes |
| s_w_last | input | 1 | Upstream last beat of burst |
| s_w_valid | input | 1 | Upstream data valid |
| s_w_ready | output | 1 | Upstream data ready |
| s_b_id | output | ID_W | Upstream response id |
| s_b_resp | output | 2 | Upstream response code |
| s_b_valid | output | 1 | Upstream response valid |
| s_b_ready | input | 1 | Upstream response ready |
| m_aw_id | output | ID_W | Downstream address id |
| m_aw_addr | output | ADDR_W | Downstream address |
| m_aw_len | output | LEN_W | Downstream burst length minus one |
| m_aw_valid | output | 1 | Downstream address valid |
| m_aw_ready | input | 1 | Downstream address ready |
| m_w_data | output | DATA_W | Downstream write data |
| m_w_strb | output | DATA_W/8 | Downstream byte strobes |
| m_w_last | output | 1 | Downstream last beat |
| m_w_valid | output | 1 | Downstream data valid |
| m_w_ready | input | 1 | Downstream data ready |
| m_b_id | input | ID_W | Downstream response id |
| m_b_resp | input | 2 | Downstream response code |
| m_b_valid | input | 1 | Downstream response valid |
| m_b_ready | output | 1 | Downstream response ready |

## Verification
The hardest case to reach is a released burst running downstream while the next burst's beats are still arriving upstream with gaps. In that case the gate has to keep the partial burst behind the complete one. The bench drives address and data concurrently, with random idle cycles between upstream beats, and throttles the downstream ready signals with a pseudo-random pattern. This makes bursts overlap across every length from one to the full queue depth. Separate stall phases fill the data queue to exactly its depth and the address queue to its limit, and then release them.

// File: rtl/wpf_pkg.sv
// Shared helpers for the write-path packet buffer.
// Assumes depths and maxima are at least 1.
package wpf_pkg;

    // Width of a counter that must hold values 0..n inclusive.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Width of an index addressing n slots (at least one bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wpf_sync_fifo.sv
// Single-clock show-ahead FIFO with a valid/ready handshake on both sides.
// The output word is taken from the read slot without a register stage.
// Assumes DEPTH >= 1. DEPTH need not be a power of two.
module wpf_sync_fifo
    import wpf_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [WIDTH-1:0]               in_data,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic [WIDTH-1:0]               out_data,
    output logic [cnt_width(DEPTH)-1:0]    level
);
    localparam int unsigned PTR_W = idx_width(DEPTH);
    localparam int unsigned CNT_W = cnt_width(DEPTH);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_LVL  = CNT_W'(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;
    logic             push;
    logic             pop;

    // Handshake qualification on both sides.
    always_comb begin
        in_ready  = (level != FULL_LVL);
        out_valid = (level != '0);
        push      = in_valid && in_ready;
        pop       = out_valid && out_ready;
        out_data  = store[rd_idx];
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_idx] <= in_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_idx <= (wr_idx == LAST_SLOT) ? '0 : wr_idx + 1'b1;
            end
            if (pop) begin
                rd_idx <= (rd_idx == LAST_SLOT) ? '0 : rd_idx + 1'b1;
            end
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R5: occupancy never exceeds the configured depth.
    p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);

    // R4: a word stays at the output until it is taken.
    p_head_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/wpf_updown.sv
// Up/down occupancy counter with simultaneous increment and decrement.
// Assumes callers never decrement at zero or increment at MAX without a
// matching opposite event; the assertions guard both.
module wpf_updown
    import wpf_pkg::*;
#(
    parameter int unsigned MAX = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inc,
    input  logic                        dec,
    output logic [cnt_width(MAX)-1:0]   count,
    output logic                        nonzero
);
    localparam int unsigned CNT_W = cnt_width(MAX);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX);

    // Flag for gating logic.
    always_comb begin
        nonzero = (count != '0);
    end

    // Count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: no decrement from zero.
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |-> (count != '0));

    // R2: no increment past the maximum.
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec) |-> (count != TOP));

endmodule

// File: rtl/wpf_release_gate.sv
// Decides when the queued address and the queued data may go downstream.
// Packet variant: an address waits for a complete stored burst, and data
// flows only for bursts whose address has already left. Streaming variant:
// both queues drain freely. Assumes event pulses are single-cycle handshakes.
module wpf_release_gate
    import wpf_pkg::*;
#(
    parameter bit          PACKET_MODE = 1'b1,
    parameter int unsigned MAX_BURSTS  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            last_stored,
    input  logic                            aw_fire,
    input  logic                            last_sent,
    input  logic                            aw_pending,
    input  logic                            w_pending,
    output logic                            aw_go,
    output logic                            w_go,
    output logic [cnt_width(MAX_BURSTS)-1:0] complete_cnt
);
    localparam int unsigned CNT_W = cnt_width(MAX_BURSTS);

    generate
        if (PACKET_MODE) begin : g_packet
            logic             complete_nz;
            logic             open_nz;
            logic [CNT_W-1:0] open_cnt;

            // Bursts fully stored whose address is still held.
            wpf_updown #(.MAX(MAX_BURSTS)) u_complete (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc     (last_stored),
                .dec     (aw_fire),
                .count   (complete_cnt),
                .nonzero (complete_nz)
            );

            // Bursts whose address has left but whose last beat has not.
            wpf_updown #(.MAX(MAX_BURSTS)) u_open (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc     (aw_fire),
                .dec     (last_sent),
                .count   (open_cnt),
                .nonzero (open_nz)
            );

            // Release decisions.
            always_comb begin
                aw_go = aw_pending && complete_nz;
                w_go  = w_pending && open_nz;
            end

            // R10: a last beat never leaves unless its burst was released.
            p_last_after_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
                last_sent |-> (open_cnt != '0));
        end else begin : g_stream
            // Free-running release; event inputs are not needed here.
            always_comb begin
                aw_go        = aw_pending;
                w_go         = w_pending;
                complete_cnt = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/wr_pkt_fifo.sv
// Write-path buffer between an upstream AXI master and a downstream slave.
// Address and data each have their own queue. With PACKET_MODE set, an
// address is released only after its whole burst is stored, so a downstream
// burst never pauses on an empty queue. Responses pass through as wires.
// Assumes upstream follows AXI valid/ready rules and, in packet mode, that
// no burst is longer than W_DEPTH beats.
module wr_pkt_fifo
    import wpf_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ID_W        = 4,
    parameter int unsigned LEN_W       = 8,
    parameter int unsigned AW_DEPTH    = 4,
    parameter int unsigned W_DEPTH     = 32,
    parameter bit          PACKET_MODE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ID_W-1:0]      s_aw_id,
    input  logic [ADDR_W-1:0]    s_aw_addr,
    input  logic [LEN_W-1:0]     s_aw_len,
    input  logic                 s_aw_valid,
    output logic                 s_aw_ready,
    input  logic [DATA_W-1:0]    s_w_data,
    input  logic [DATA_W/8-1:0]  s_w_strb,
    input  logic                 s_w_last,
    input  logic                 s_w_valid,
    output logic                 s_w_ready,
    output logic [ID_W-1:0]      s_b_id,
    output logic [1:0]           s_b_resp,
    output logic                 s_b_valid,
    input  logic                 s_b_ready,
    output logic [ID_W-1:0]      m_aw_id,
    output logic [ADDR_W-1:0]    m_aw_addr,
    output logic [LEN_W-1:0]     m_aw_len,
    output logic                 m_aw_valid,
    input  logic                 m_aw_ready,
    output logic [DATA_W-1:0]    m_w_data,
    output logic [DATA_W/8-1:0]  m_w_strb,
    output logic                 m_w_last,
    output logic                 m_w_valid,
    input  logic                 m_w_ready,
    input  logic [ID_W-1:0]      m_b_id,
    input  logic [1:0]           m_b_resp,
    input  logic                 m_b_valid,
    output logic                 m_b_ready
);
    localparam int unsigned STRB_W   = DATA_W / 8;
    localparam int unsigned AW_BITS  = ID_W + ADDR_W + LEN_W;
    localparam int unsigned W_BITS   = DATA_W + STRB_W + 1;
    localparam int unsigned AWCNT_W  = cnt_width(AW_DEPTH);
    localparam int unsigned WCNT_W   = cnt_width(W_DEPTH);

    logic [AW_BITS-1:0] aw_in_word;
    logic [AW_BITS-1:0] aw_out_word;
    logic               aw_q_valid;
    logic [AWCNT_W-1:0] aw_level;
    logic [W_BITS-1:0]  w_in_word;
    logic [W_BITS-1:0]  w_out_word;
    logic               w_q_valid;
    logic [WCNT_W-1:0]  w_level;
    logic               aw_go;
    logic               w_go;
    logic               last_stored;
    logic               aw_fire;
    logic               last_sent;
    logic [WCNT_W-1:0]  complete_cnt;

    // Pack upstream fields and unpack downstream fields.
    always_comb begin
        aw_in_word                          = {s_aw_id, s_aw_addr, s_aw_len};
        w_in_word                           = {s_w_data, s_w_strb, s_w_last};
        {m_aw_id, m_aw_addr, m_aw_len}      = aw_out_word;
        {m_w_data, m_w_strb, m_w_last}      = w_out_word;
    end

    // Address queue.
    wpf_sync_fifo #(.WIDTH(AW_BITS), .DEPTH(AW_DEPTH)) u_aw_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_aw_valid),
        .in_ready  (s_aw_ready),
        .in_data   (aw_in_word),
        .out_valid (aw_q_valid),
        .out_ready (m_aw_ready && aw_go),
        .out_data  (aw_out_word),
        .level     (aw_level)
    );

    // Data queue.
    wpf_sync_fifo #(.WIDTH(W_BITS), .DEPTH(W_DEPTH)) u_w_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_w_valid),
        .in_ready  (s_w_ready),
        .in_data   (w_in_word),
        .out_valid (w_q_valid),
        .out_ready (m_w_ready && w_go),
        .out_data  (w_out_word),
        .level     (w_level)
    );

    // Handshake events seen by the release gate.
    always_comb begin
        m_aw_valid  = aw_go;
        m_w_valid   = w_go;
        last_stored = s_w_valid && s_w_ready && s_w_last;
        aw_fire     = aw_go && m_aw_ready;
        last_sent   = w_go && m_w_ready && m_w_last;
    end

    // Release policy.
    wpf_release_gate #(.PACKET_MODE(PACKET_MODE), .MAX_BURSTS(W_DEPTH)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .last_stored  (last_stored),
        .aw_fire      (aw_fire),
        .last_sent    (last_sent),
        .aw_pending   (aw_q_valid),
        .w_pending    (w_q_valid),
        .aw_go        (aw_go),
        .w_go         (w_go),
        .complete_cnt (complete_cnt)
    );

    // Response channel wiring.
    always_comb begin
        s_b_id    = m_b_id;
        s_b_resp  = m_b_resp;
        s_b_valid = m_b_valid;
        m_b_ready = s_b_ready;
    end

    // R9: in packet mode every burst must fit in the data queue.
    p_len_fits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (PACKET_MODE && s_aw_valid && s_aw_ready) |-> ((int'(s_aw_len) + 1) <= int'(W_DEPTH)));

    // R3: no downstream gap inside a burst in packet mode.
    p_no_mid_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (PACKET_MODE && m_w_valid && m_w_ready && !m_w_last) |=> m_w_valid);

    // R2: held complete bursts never outnumber stored beats.
    p_bursts_le_beats_r2: assert property (@(posedge clk) disable iff (!rst_n)
        complete_cnt <= w_level);

    // R4: a presented address holds until accepted.
    p_aw_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_aw_valid && !m_aw_ready) |=> (m_aw_valid && $stable(m_aw_addr) && $stable(m_aw_len)));

    // R6: address queue occupancy is bounded.
    p_aw_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        aw_level <= AWCNT_W'(AW_DEPTH));

endmodule

// File: tb/tb_wr_pkt_fifo.sv
module tb_wr_pkt_fifo;
    localparam int AW_W = 16, DW = 16, IDW = 2, LW = 8, AWD = 4, WD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // Packet-mode instance signals.
    logic [IDW-1:0] s_aw_id = '0;  logic [AW_W-1:0] s_aw_addr = '0;
    logic [LW-1:0]  s_aw_len = '0; logic s_aw_valid = 1'b0; logic s_aw_ready;
    logic [DW-1:0]  s_w_data = '0; logic [DW/8-1:0] s_w_strb = '0;
    logic s_w_last = 1'b0, s_w_valid = 1'b0; logic s_w_ready;
    logic [IDW-1:0] s_b_id; logic [1:0] s_b_resp; logic s_b_valid; logic s_b_ready = 1'b0;
    logic [IDW-1:0] m_aw_id; logic [AW_W-1:0] m_aw_addr; logic [LW-1:0] m_aw_len;
    logic m_aw_valid; logic m_aw_ready = 1'b0;
    logic [DW-1:0] m_w_data; logic [DW/8-1:0] m_w_strb; logic m_w_last, m_w_valid;
    logic m_w_ready = 1'b0;
    logic [IDW-1:0] m_b_id = '0; logic [1:0] m_b_resp = '0; logic m_b_valid = 1'b0; logic m_b_ready;

    // Streaming-mode instance signals.
    logic [AW_W-1:0] p_aw_addr = '0; logic p_aw_valid = 1'b0; logic p_aw_ready;
    logic [DW-1:0] p_w_data = '0; logic p_w_last = 1'b0, p_w_valid = 1'b0; logic p_w_ready;
    logic [IDW-1:0] p_b_id; logic [1:0] p_b_resp; logic p_b_valid; logic p_m_b_ready;
    logic [IDW-1:0] p_m_aw_id; logic [AW_W-1:0] p_m_aw_addr; logic [LW-1:0] p_m_aw_len;
    logic p_m_aw_valid; logic [DW-1:0] p_m_w_data; logic [DW/8-1:0] p_m_w_strb;
    logic p_m_w_last, p_m_w_valid;

    wr_pkt_fifo #(.ADDR_W(AW_W), .DATA_W(DW), .ID_W(IDW), .LEN_W(LW),
                  .AW_DEPTH(AWD), .W_DEPTH(WD), .PACKET_MODE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n),
        .s_aw_id(s_aw_id), .s_aw_addr(s_aw_addr), .s_aw_len(s_aw_len),
        .s_aw_valid(s_aw_valid), .s_aw_ready(s_aw_ready),
        .s_w_data(s_w_data), .s_w_strb(s_w_strb), .s_w_last(s_w_last),
        .s_w_valid(s_w_valid), .s_w_ready(s_w_ready),
        .s_b_id(s_b_id), .s_b_resp(s_b_resp), .s_b_valid(s_b_valid), .s_b_ready(s_b_ready),
        .m_aw_id(m_aw_id), .m_aw_addr(m_aw_addr), .m_aw_len(m_aw_len),
        .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready),
        .m_w_data(m_w_data), .m_w_strb(m_w_strb), .m_w_last(m_w_last),
        .m_w_valid(m_w_valid), .m_w_ready(m_w_ready),
        .m_b_id(m_b_id), .m_b_resp(m_b_resp), .m_b_valid(m_b_valid), .m_b_ready(m_b_ready));

    wr_pkt_fifo #(.ADDR_W(AW_W), .DATA_W(DW), .ID_W(IDW), .LEN_W(LW),
                  .AW_DEPTH(AWD), .W_DEPTH(WD), .PACKET_MODE(1'b0)) dut_pt (
        .clk(clk), .rst_n(rst_n),
        .s_aw_id('0), .s_aw_addr(p_aw_addr), .s_aw_len(8'd3),
        .s_aw_valid(p_aw_valid), .s_aw_ready(p_aw_ready),
        .s_w_data(p_w_data), .s_w_strb('1), .s_w_last(p_w_last),
        .s_w_valid(p_w_valid), .s_w_ready(p_w_ready),
        .s_b_id(p_b_id), .s_b_resp(p_b_resp), .s_b_valid(p_b_valid), .s_b_ready(1'b0),
        .m_aw_id(p_m_aw_id), .m_aw_addr(p_m_aw_addr), .m_aw_len(p_m_aw_len),
        .m_aw_valid(p_m_aw_valid), .m_aw_ready(1'b0),
        .m_w_data(p_m_w_data), .m_w_strb(p_m_w_strb), .m_w_last(p_m_w_last),
        .m_w_valid(p_m_w_valid), .m_w_ready(1'b0),
        .m_b_id('0), .m_b_resp('0), .m_b_valid(1'b0), .m_b_ready(p_m_b_ready));

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard state.
    logic [AW_W-1:0] sb_addr [1024];
    logic [LW-1:0]   sb_len  [1024];
    logic [DW-1:0]   sb_data [1024];
    logic            sb_last [1024];
    int aw_in = 0, aw_out = 0, w_in = 0, w_out = 0;
    int lasts_in = 0, lasts_out = 0;
    bit in_burst = 1'b0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    // Downstream ready driving and monitoring of the packet instance.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: begin m_aw_ready = 1'b1; m_w_ready = 1'b1; end
            1: begin m_aw_ready = lfsr[0]; m_w_ready = lfsr[3] | lfsr[7]; end
            2: begin m_aw_ready = 1'b0; m_w_ready = 1'b0; end
            default: begin m_aw_ready = lfsr[1] & lfsr[2]; m_w_ready = lfsr[4] & lfsr[5]; end
        endcase
        if (rst_n) begin
            if (m_aw_valid)
                chk(lasts_in > aw_out, "R2 address released before burst stored", aw_out, lasts_in);
            if (m_w_valid)
                chk(aw_out > lasts_out, "R10 data presented before its address", lasts_out, aw_out);
            if (in_burst)
                chk(m_w_valid, "R3 gap inside downstream burst", m_w_valid, 1);
            if (m_aw_valid && m_aw_ready) begin
                chk(m_aw_addr == sb_addr[aw_out % 1024], "R4 address order", m_aw_addr, sb_addr[aw_out % 1024]);
                chk(m_aw_len == sb_len[aw_out % 1024], "R4 length order", m_aw_len, sb_len[aw_out % 1024]);
                aw_out++;
            end
            if (m_w_valid && m_w_ready) begin
                chk(m_w_data == sb_data[w_out % 1024], "R4 data order", m_w_data, sb_data[w_out % 1024]);
                chk(m_w_last == sb_last[w_out % 1024], "R4 last flag order", m_w_last, sb_last[w_out % 1024]);
                w_out++;
                in_burst = !m_w_last;
                if (m_w_last) lasts_out++;
            end
            if (s_aw_valid && s_aw_ready) begin
                sb_addr[aw_in % 1024] = s_aw_addr;
                sb_len[aw_in % 1024]  = s_aw_len;
                aw_in++;
            end
            if (s_w_valid && s_w_ready) begin
                sb_data[w_in % 1024] = s_w_data;
                sb_last[w_in % 1024] = s_w_last;
                w_in++;
                if (s_w_last) lasts_in++;
            end
        end
    end

    task automatic put_aw(input logic [AW_W-1:0] a, input logic [LW-1:0] l);
        bit hs;
        @(posedge clk); #1;
        s_aw_addr = a; s_aw_len = l; s_aw_id = a[1:0]; s_aw_valid = 1'b1;
        forever begin
            hs = s_aw_ready;
            @(posedge clk); #1;
            if (hs) break;
        end
        s_aw_valid = 1'b0;
    endtask

    task automatic put_w(input logic [DW-1:0] base, input int len, input int gap);
        bit hs;
        @(posedge clk); #1;
        for (int b = 0; b <= len; b++) begin
            s_w_data = base + DW'(b); s_w_strb = '1; s_w_last = (b == len); s_w_valid = 1'b1;
            forever begin
                hs = s_w_ready;
                @(posedge clk); #1;
                if (hs) break;
            end
            if (gap > 0 && b != len && lfsr[6]) begin
                s_w_valid = 1'b0;
                repeat (gap) begin @(posedge clk); #1; end
            end
        end
        s_w_valid = 1'b0; s_w_last = 1'b0;
    endtask

    task automatic drain();
        while (aw_out != aw_in || w_out != w_in) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int k;
        k = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle outputs during reset.
        chk(!m_aw_valid, "R1 m_aw_valid in reset", m_aw_valid, 0);
        chk(!m_w_valid, "R1 m_w_valid in reset", m_w_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(s_aw_ready && s_w_ready, "R1 ready after reset", {s_aw_ready, s_w_ready}, 3);

        // R8: response wires.
        @(posedge clk); #1;
        m_b_valid = 1'b1; m_b_id = 2'd2; m_b_resp = 2'd2; s_b_ready = 1'b1;
        @(negedge clk);
        chk(s_b_valid && s_b_id == 2'd2 && s_b_resp == 2'd2, "R8 response forward", {s_b_valid, s_b_id, s_b_resp}, 5'b11010);
        chk(m_b_ready, "R8 ready back", m_b_ready, 1);
        s_b_ready = 1'b0; m_b_valid = 1'b0;
        #1;
        chk(!m_b_ready && !s_b_valid, "R8 deassert", {m_b_ready, s_b_valid}, 0);

        // R2/R10 directed: address waits for the last beat.
        rdy_mode = 0;
        put_aw(16'h0100, 8'd3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!m_aw_valid, "R2 address held without data", m_aw_valid, 0);
        put_w(16'h1000, 3, 0);
        chk(m_aw_valid, "R2 address released after last beat", m_aw_valid, 1);
        chk(!m_w_valid, "R10 data held until address leaves", m_w_valid, 0);
        drain();

        // Sweep of lengths and downstream ready patterns.
        for (int mode = 0; mode < 4; mode++) begin
            if (mode == 2) continue;
            rdy_mode = mode;
            for (int len = 0; len < WD; len++) begin
                for (int rep = 0; rep < 2; rep++) begin
                    fork
                        put_aw(AW_W'(k * 16), LW'(len));
                        put_w(DW'(k * 256), len, rep + 1);
                    join
                    k++;
                end
            end
            drain();
        end

        // R5: fill the data queue exactly.
        rdy_mode = 2;
        put_aw(16'h0F00, 8'(WD - 1));
        put_w(16'h7000, WD - 1, 0);
        @(negedge clk);
        chk(!s_w_ready, "R5 data queue full", s_w_ready, 0);
        rdy_mode = 0;
        @(negedge clk); @(negedge clk);
        chk(s_w_ready, "R5 ready after drain starts", s_w_ready, 1);
        drain();

        // R6: fill the address queue.
        rdy_mode = 2;
        for (int i = 0; i < AWD; i++) put_aw(AW_W'(16'h0E00 + i), 8'd0);
        @(negedge clk);
        chk(!s_aw_ready, "R6 address queue full", s_aw_ready, 0);
        for (int i = 0; i < AWD; i++) put_w(DW'(16'h6000 + i), 0, 0);
        rdy_mode = 1;
        drain();
        chk(s_aw_ready, "R6 ready after drain", s_aw_ready, 1);

        // R7: streaming instance releases without waiting.
        @(posedge clk); #1;
        p_aw_addr = 16'h0ABC; p_aw_valid = 1'b1;
        @(posedge clk); #1;
        p_aw_valid = 1'b0;
        @(negedge clk);
        chk(p_m_aw_valid && p_m_aw_addr == 16'h0ABC, "R7 address out without data", p_m_aw_addr, 16'h0ABC);
        chk(!p_m_w_valid, "R7 no data yet", p_m_w_valid, 0);
        @(posedge clk); #1;
        p_w_data = 16'h55AA; p_w_last = 1'b0; p_w_valid = 1'b1;
        @(posedge clk); #1;
        p_w_valid = 1'b0;
        @(negedge clk);
        chk(p_m_w_valid && p_m_w_data == 16'h55AA, "R7 partial burst beat presented", p_m_w_data, 16'h55AA);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule